// File: doc/BRIEF.md
# Interrupt Table Register and Descriptor Locator

This block keeps the register that tells the processor where its interrupt table lives. The register holds a 32-bit linear base and a 16-bit limit. Software loads the register from a 6-byte image and can read it back in the same 6-byte form. A load is accepted only at the most privileged level, which is level 0. A readback is allowed at every level.

For every incoming 8-bit interrupt or exception identifier, the block forms the linear address of the 8-byte descriptor that serves that identifier. The address is the base plus eight times the identifier, taken modulo 2^32. The block also checks that all eight bytes of that entry fall inside the limit. If any byte falls outside, the block flags a limit violation and issues no address. Entry 0 is an ordinary slot. The base needs no alignment.

All results are registered and appear one clock after the request. Each result is computed from the register contents as they stood when the request was taken.

Top module: `irq_table_locator`

## Requirements
- R1: After reset the base is 0x00000000 and the limit is 0x07FF, so a readback right after reset returns the image 0x0000_0000_07FF.
- R2: In the 6-byte image, bits 15:0 hold the limit and bits 47:16 hold the base, both little-endian. A load request at privilege level 0 writes both fields, and the new values are used from the next cycle on.
- R3: A load request at any privilege level other than 0 is rejected and leaves base and limit unchanged. `privFault` is high for exactly the cycle after that request, and low after every other cycle.
- R4: A store request at any privilege level sets `storeValid` high in the next cycle, and `storeImage` then carries the current base and limit in the R2 layout.
- R5: For a lookup request with identifier `id`, the cycle after the request shows `descAddr` = base + id*8 modulo 2^32 and `addrValid` high, provided the entry is in range.
- R6: An entry is in range only when id*8 + 7 <= limit. Otherwise the cycle after the request shows `limitFault` high, `addrValid` low and `descAddr` equal to 0.
- R7: Identifier 0 is a legal entry. It resolves to the base itself whenever the limit is 7 or more.
- R8: The base is added exactly as loaded, with no alignment, so odd bases and bases near 2^32 give unaligned or wrapped addresses.
- R9: When a load shares a cycle with a store or a lookup, the store and the lookup use the register value from before the load.
- R10: After a cycle that has no request, `storeValid`, `addrValid`, `limitFault` and `privFault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curPriv | input | 2 | Current privilege level (0 = most privileged) |
| loadReq | input | 1 | Request to load the register from loadImage |
| loadImage | input | 48 | Image to load: limit in bits 15:0, base in bits 47:16 |
| storeReq | input | 1 | Request to read the register back |
| storeImage | output | 48 | Register image returned by the last store |
| storeValid | output | 1 | storeImage was updated in the previous cycle |
| privFault | output | 1 | The previous cycle's load was rejected |
| lookupReq | input | 1 | Request to locate a descriptor |
| vectorId | input | 8 | Interrupt or exception identifier |
| descAddr | output | 32 | Linear address of the descriptor, or 0 |
| addrValid | output | 1 | descAddr is valid |
| limitFault | output | 1 | The requested entry lies outside the limit |

## Verification
The assertions assume that the request inputs and `curPriv` are stable across each rising edge and never take unknown values once reset is released. The bench meets this by changing every input only on the falling edge. The assertions also assume that a load, a store and a lookup may arrive in any mix within one cycle. The random stimulus therefore draws each request independently, draws limits that are often small so that both outcomes of the range check occur, and draws every privilege level.

// File: rtl/itl_pkg.sv
package itl_pkg;
  localparam int BASE_W  = 32;
  localparam int LIMIT_W = 16;
  localparam int IMG_W   = BASE_W + LIMIT_W;

  typedef struct packed {
    logic doLoad;
    logic doStore;
    logic doLookup;
    logic rejectLoad;
  } itlStrobes_t;
endpackage

// File: rtl/itl_ctrl.sv
module itl_ctrl #(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              loadReq,
  input  logic              storeReq,
  input  logic              lookupReq,
  output itl_pkg::itlStrobes_t strb,
  output logic              privFault
);
  logic privOk;

  assign privOk = (curPriv == '0);

  always_comb begin
    strb.doLoad     = loadReq && privOk;
    strb.rejectLoad = loadReq && !privOk;
    strb.doStore    = storeReq;
    strb.doLookup   = lookupReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= strb.rejectLoad;
  end
endmodule

// File: rtl/itl_datapath.sv
module itl_datapath #(
  parameter int BASE_W      = 32,
  parameter int LIMIT_W     = 16,
  parameter int ID_W        = 8,
  parameter int ENTRY_SHIFT = 3,
  parameter logic [LIMIT_W-1:0] RESET_LIMIT = 16'h07FF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  itl_pkg::itlStrobes_t      strb,
  input  logic [BASE_W+LIMIT_W-1:0] loadImage,
  input  logic [ID_W-1:0]           vectorId,
  output logic [BASE_W+LIMIT_W-1:0] storeImage,
  output logic                      storeValid,
  output logic [BASE_W-1:0]         descAddr,
  output logic                      addrValid,
  output logic                      limitFault
);
  localparam int IMG_W  = BASE_W + LIMIT_W;
  localparam int OFF_W  = ID_W + ENTRY_SHIFT;
  localparam int CMP_W  = (OFF_W > LIMIT_W ? OFF_W : LIMIT_W) + 1;
  localparam int ENTRY_LAST = (1 << ENTRY_SHIFT) - 1;

  logic [BASE_W-1:0]  baseQ;
  logic [LIMIT_W-1:0] limitQ;
  logic [OFF_W-1:0]   entryOff;
  logic [CMP_W-1:0]   entryEnd;
  logic               inRange;
  logic [BASE_W-1:0]  sumAddr;

  assign entryOff = {vectorId, {ENTRY_SHIFT{1'b0}}};
  assign entryEnd = CMP_W'(entryOff) + CMP_W'(ENTRY_LAST);
  assign inRange  = entryEnd <= CMP_W'(limitQ);
  assign sumAddr  = baseQ + BASE_W'(entryOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ      <= '0;
      limitQ     <= RESET_LIMIT;
      storeImage <= '0;
      storeValid <= 1'b0;
      descAddr   <= '0;
      addrValid  <= 1'b0;
      limitFault <= 1'b0;
    end else begin
      if (strb.doLoad) begin
        limitQ <= loadImage[LIMIT_W-1:0];
        baseQ  <= loadImage[IMG_W-1:LIMIT_W];
      end
      storeValid <= strb.doStore;
      if (strb.doStore) storeImage <= {baseQ, limitQ};
      addrValid  <= strb.doLookup && inRange;
      limitFault <= strb.doLookup && !inRange;
      descAddr   <= (strb.doLookup && inRange) ? sumAddr : '0;
    end
  end
endmodule

// File: rtl/irq_table_locator.sv
module irq_table_locator #(
  parameter int PRIV_W      = 2,
  parameter int ID_W        = 8,
  parameter int ENTRY_SHIFT = 3,
  parameter logic [15:0] RESET_LIMIT = 16'h07FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              loadReq,
  input  logic [47:0]       loadImage,
  input  logic              storeReq,
  output logic [47:0]       storeImage,
  output logic              storeValid,
  output logic              privFault,
  input  logic              lookupReq,
  input  logic [ID_W-1:0]   vectorId,
  output logic [31:0]       descAddr,
  output logic              addrValid,
  output logic              limitFault
);
  itl_pkg::itlStrobes_t strb;

  itl_ctrl #(.PRIV_W(PRIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .curPriv(curPriv), .loadReq(loadReq),
    .storeReq(storeReq), .lookupReq(lookupReq), .strb(strb),
    .privFault(privFault)
  );

  itl_datapath #(
    .BASE_W(itl_pkg::BASE_W), .LIMIT_W(itl_pkg::LIMIT_W), .ID_W(ID_W),
    .ENTRY_SHIFT(ENTRY_SHIFT), .RESET_LIMIT(RESET_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadImage(loadImage),
    .vectorId(vectorId), .storeImage(storeImage), .storeValid(storeValid),
    .descAddr(descAddr), .addrValid(addrValid), .limitFault(limitFault)
  );
endmodule

// File: rtl/itl_chk.sv
module itl_chk #(
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PRIV_W-1:0] curPriv,
  input logic              loadReq,
  input logic              storeReq,
  input logic              lookupReq,
  input logic              storeValid,
  input logic              privFault,
  input logic [31:0]       descAddr,
  input logic              addrValid,
  input logic              limitFault
);
  // R3
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && curPriv != '0) |=> privFault);
  // R3
  accept_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadReq && curPriv != '0) |=> !privFault);
  // R4
  store_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> storeValid);
  // R5
  lookup_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> $countones({addrValid, limitFault}) == 1);
  // R6
  fault_noaddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> descAddr == '0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadReq || storeReq || lookupReq) |=>
      !(storeValid || addrValid || limitFault || privFault));
endmodule

bind irq_table_locator itl_chk #(.PRIV_W(PRIV_W)) chk_i (
  .clk(clk), .rstN(rstN), .curPriv(curPriv), .loadReq(loadReq),
  .storeReq(storeReq), .lookupReq(lookupReq), .storeValid(storeValid),
  .privFault(privFault), .descAddr(descAddr), .addrValid(addrValid),
  .limitFault(limitFault)
);

// File: tb/irq_table_locator_test.sv
`timescale 1ns/1ps
module irq_table_locator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  curPriv = '0;
  logic        loadReq = 1'b0;
  logic [47:0] loadImage = '0;
  logic        storeReq = 1'b0;
  logic        lookupReq = 1'b0;
  logic [7:0]  vectorId = '0;
  logic [47:0] storeImage;
  logic        storeValid, privFault, addrValid, limitFault;
  logic [31:0] descAddr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] mBase;
  logic [15:0] mLimit;

  always #5 clk = ~clk;

  irq_table_locator uut (
    .clk(clk), .rstN(rstN), .curPriv(curPriv), .loadReq(loadReq),
    .loadImage(loadImage), .storeReq(storeReq), .storeImage(storeImage),
    .storeValid(storeValid), .privFault(privFault), .lookupReq(lookupReq),
    .vectorId(vectorId), .descAddr(descAddr), .addrValid(addrValid),
    .limitFault(limitFault)
  );

  function automatic logic [31:0] expAddr(logic [31:0] b, logic [7:0] id);
    return b + {21'd0, id, 3'b000};
  endfunction

  function automatic bit expInRange(logic [15:0] lim, logic [7:0] id);
    logic [16:0] last;
    last = {6'd0, id, 3'b000} + 17'd7;
    return last <= {1'b0, lim};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply one cycle of requests, then check the results one cycle later.
  task automatic step(string req, bit ld, logic [47:0] img, logic [1:0] pl,
                      bit st, bit lk, logic [7:0] id);
    bit inR;
    @(negedge clk);
    loadReq = ld; loadImage = img; curPriv = pl;
    storeReq = st; lookupReq = lk; vectorId = id;
    @(posedge clk);
    @(negedge clk);
    loadReq = 1'b0; storeReq = 1'b0; lookupReq = 1'b0;
    inR = expInRange(mLimit, id);
    chk(req, "privFault", 64'(privFault), 64'(ld && pl != 2'd0));
    chk(req, "storeValid", 64'(storeValid), 64'(st));
    if (st) chk(req, "storeImage", 64'(storeImage), 64'({mBase, mLimit}));
    chk(req, "addrValid", 64'(addrValid), 64'(lk && inR));
    chk(req, "limitFault", 64'(limitFault), 64'(lk && !inR));
    chk(req, "descAddr", 64'(descAddr), (lk && inR) ? 64'(expAddr(mBase, id)) : 64'd0);
    if (ld && pl == 2'd0) begin
      mLimit = img[15:0];
      mBase  = img[47:16];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1d7c);
    mBase = 32'h0; mLimit = 16'h07FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "reset storeValid", 64'(storeValid), 64'd0);
    chk("R1", "reset addrValid", 64'(addrValid), 64'd0);
    step("R1", 0, '0, 2'd0, 1, 0, 8'd0);
    chk("R1", "reset image", 64'(storeImage), 64'h0000_0000_07FF);
    // R6 top entry with reset limit is in range; R7 entry 0
    step("R6", 0, '0, 2'd3, 0, 1, 8'hFF);
    step("R7", 0, '0, 2'd1, 0, 1, 8'h00);
    // R2 privileged load, then readback at level 3 (R4)
    step("R2", 1, {32'h1234_5679, 16'h0017}, 2'd0, 0, 0, 8'd0);
    step("R4", 0, '0, 2'd3, 1, 0, 8'd0);
    chk("R2", "loaded image", 64'(storeImage), 64'h1234_5679_0017);
    // R6 limit 0x17: ids 0..2 fit, id 3 does not
    step("R6", 0, '0, 2'd0, 0, 1, 8'd2);
    step("R6", 0, '0, 2'd0, 0, 1, 8'd3);
    // R8 odd base used as-is
    step("R8", 0, '0, 2'd2, 0, 1, 8'd1);
    chk("R8", "odd base addr", 64'(descAddr), 64'h1234_5681);
    // R3 rejected loads at levels 1..3 leave register unchanged
    for (int p = 1; p < 4; p++)
      step("R3", 1, {32'hDEAD_BEEF, 16'hFFFF}, 2'(p), 0, 0, 8'd0);
    step("R3", 0, '0, 2'd0, 1, 0, 8'd0);
    chk("R3", "image after reject", 64'(storeImage), 64'h1234_5679_0017);
    // R7 entry 0 with limit exactly 7, and out of range with limit 6
    step("R7", 1, {32'h0000_1000, 16'h0007}, 2'd0, 0, 0, 8'd0);
    step("R7", 0, '0, 2'd0, 0, 1, 8'd0);
    chk("R7", "entry0 at base", 64'(descAddr), 64'h0000_1000);
    step("R7", 1, {32'h0000_1000, 16'h0006}, 2'd0, 0, 0, 8'd0);
    step("R7", 0, '0, 2'd0, 0, 1, 8'd0);
    // R8 wraparound modulo 2^32
    step("R8", 1, {32'hFFFF_FFFD, 16'hFFFF}, 2'd0, 0, 0, 8'd0);
    step("R8", 0, '0, 2'd0, 0, 1, 8'd1);
    chk("R8", "wrapped addr", 64'(descAddr), 64'h0000_0005);
    // R9 load together with store and lookup uses old value
    step("R9", 1, {32'h0000_0100, 16'h0000}, 2'd0, 1, 1, 8'd4);
    chk("R9", "old image", 64'(storeImage), 64'hFFFF_FFFD_FFFF);
    step("R9", 0, '0, 2'd0, 1, 1, 8'd0);
    // R10 idle cycles
    step("R10", 0, '0, 2'd0, 0, 0, 8'd0);
    step("R10", 0, '0, 2'd3, 0, 0, 8'hAA);
    // R5 random mix
    for (int i = 0; i < 400; i++) begin
      logic [47:0] img;
      logic [15:0] lim;
      lim = ($urandom % 2) ? 16'($urandom % 2100) : 16'($urandom);
      img = {32'($urandom), lim};
      step("R5", ($urandom % 4) == 0, img, 2'($urandom), ($urandom % 3) == 0,
           ($urandom % 2) == 0, 8'($urandom));
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule